// File: doc/BRIEF.md
# Worst-Case Ethernet Arrival Generator

This block produces the heaviest legal receive load a buffer can see: a steady stream of equal-size Ethernet frames. Each frame follows the previous one with only the mandatory 96-bit-time interframe gap between them. A two-bit class input selects minimum, maximum or jumbo frames. A two-bit rate input selects one of four line rates, and each rate has its own bit-time period, expressed in system clock cycles.

Frame arrivals are timed in bit times. A divider turns the system clock into bit-time ticks. A slot counter walks through the start-to-start period of each frame, which is the time on the wire plus the gap. When the last bit of a frame has arrived, the block raises a one-cycle strobe. With that strobe it updates the size of the frame in data blocks and a running frame count. A buffer model or a DMA engine under test consumes these outputs as its worst-case arrival pattern.

Top module: `eth_worst_arrival_gen`

## Requirements
- R1: After synchronous reset, `arrival` is 0, `frame_count` is 0 and `frame_blocks` is 0.
- R2: Class codes map to time on the wire as follows: 2'b00 is 576 bit times, 2'b01 is 12208, 2'b10 is 72208, and 2'b11 behaves as 2'b00. The first `arrival` is high in the cycle that follows the (W·D)-th rising edge after the edge at which `enable` is first sampled high, where W is the wire time and D is the bit-time divisor.
- R3: While the configuration is unchanged, successive arrivals are exactly (W+96)·D clock cycles apart.
- R4: Rate codes select D as follows: 2'b00 uses DIV_10M, 2'b01 uses DIV_100M, 2'b10 uses DIV_1G and 2'b11 uses DIV_10G. The defaults are 8, 4, 2 and 1.
- R5: `frame_blocks` loads with each arrival and holds between arrivals. Its value is ceil(B / BLOCK_BYTES), where B is W/8 − 8 bytes (64, 1518 or 9018). With the default BLOCK_BYTES of 8, this gives 8, 190 and 1128.
- R6: `frame_count` increases by exactly one in the cycle of each arrival and otherwise holds. It keeps its value while `enable` is low.
- R7: While `enable` is low, no arrival occurs, and a frame in progress is dropped. When `enable` rises again, timing restarts from zero as described in R2.
- R8: If the class or rate changes while `enable` is high, the frame in progress keeps its old timing and size. The new values take effect from the next start-to-start boundary.
- R9: `arrival` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the frame stream while high |
| frame_class | input | 2 | Frame size class code |
| line_rate | input | 2 | Line rate code selecting the bit-time divisor |
| arrival | output | 1 | One-cycle strobe when a frame has fully arrived |
| frame_blocks | output | BLK_W | Size of the arrived frame in data blocks |
| frame_count | output | CNT_W | Running count of arrived frames |

## Verification
Some properties are checked on every cycle. The strobe is a single cycle and is silent whenever `enable` is low. The frame count steps by one with each arrival and holds otherwise, and the block size changes only with an arrival. The divider and slot counters always stay below their current limits. Exact cycle distances can only be shown by the bench's scenarios, since a property cannot reach across tens of thousands of cycles. These distances are the first-arrival delay, the start-to-start spacing for each class and rate, the deferral of a mid-frame configuration change to the next boundary, and the restart after an aborted frame.

// File: rtl/eth_arrival_pkg.sv
package eth_arrival_pkg;

    typedef enum logic [1:0] {
        FC_SMALL = 2'b00,
        FC_LARGE = 2'b01,
        FC_HUGE  = 2'b10,
        FC_SPARE = 2'b11
    } frame_class_e;

    typedef enum logic [1:0] {
        LR_10M  = 2'b00,
        LR_100M = 2'b01,
        LR_1G   = 2'b10,
        LR_10G  = 2'b11
    } line_rate_e;

    typedef struct packed {
        frame_class_e cls;
        line_rate_e   rate;
    } slot_cfg_t;

    localparam int unsigned GAP_BITS       = 96;
    localparam int unsigned LEAD_BYTES     = 8;
    localparam int unsigned SMALL_WIRE     = 576;
    localparam int unsigned LARGE_WIRE     = 12208;
    localparam int unsigned HUGE_WIRE      = 72208;
    localparam int unsigned HUGE_BYTES     = HUGE_WIRE / 8 - LEAD_BYTES;
    localparam int unsigned BIT_W          = $clog2(HUGE_WIRE + GAP_BITS + 1);

    function automatic int unsigned wire_time(frame_class_e c);
        case (c)
            FC_LARGE: return LARGE_WIRE;
            FC_HUGE:  return HUGE_WIRE;
            default:  return SMALL_WIRE;
        endcase
    endfunction

    function automatic int unsigned slot_time(frame_class_e c);
        return wire_time(c) + GAP_BITS;
    endfunction

    function automatic int unsigned payload_blocks(frame_class_e c, int unsigned blk_bytes);
        int unsigned nbytes;
        nbytes = wire_time(c) / 8 - LEAD_BYTES;
        return (nbytes + blk_bytes - 1) / blk_bytes;
    endfunction

endpackage

// File: rtl/bit_tick_div.sv
module bit_tick_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < divisor));

endmodule

// File: rtl/frame_slot_timer.sv
module frame_slot_timer
    import eth_arrival_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [BIT_W-1:0] wire_len,
    input  logic [BIT_W-1:0] slot_len,
    output logic             wire_done,
    output logic             slot_done
);
    logic [BIT_W-1:0] pos_q;

    assign wire_done = run && tick && (pos_q == wire_len - BIT_W'(1));
    assign slot_done = run && tick && (pos_q == slot_len - BIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q <= '0;
        end else if (slot_done) begin
            pos_q <= '0;
        end else if (tick) begin
            pos_q <= pos_q + BIT_W'(1);
        end
    end

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos_q < slot_len));

    // R3
    gap_order_chk: assert property (@(posedge clk) disable iff (rst)
        wire_done |=> !slot_done);

endmodule

// File: rtl/eth_worst_arrival_gen.sv
module eth_worst_arrival_gen
    import eth_arrival_pkg::*;
#(
    parameter int  DIV_10M     = 8,
    parameter int  DIV_100M    = 4,
    parameter int  DIV_1G      = 2,
    parameter int  DIV_10G     = 1,
    parameter int  BLOCK_BYTES = 8,
    parameter int  CNT_W       = 16,
    localparam int BLK_W       = $clog2(HUGE_BYTES / BLOCK_BYTES + 2),
    localparam int DIV_MAX     = (DIV_10M > DIV_100M ? DIV_10M : DIV_100M) >
                                 (DIV_1G > DIV_10G ? DIV_1G : DIV_10G) ?
                                 (DIV_10M > DIV_100M ? DIV_10M : DIV_100M) :
                                 (DIV_1G > DIV_10G ? DIV_1G : DIV_10G),
    localparam int DIV_W       = $clog2(DIV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       frame_class,
    input  logic [1:0]       line_rate,
    output logic             arrival,
    output logic [BLK_W-1:0] frame_blocks,
    output logic [CNT_W-1:0] frame_count
);
    slot_cfg_t        cfg_q;
    slot_cfg_t        cfg_in;
    logic             active_q;
    logic             go;
    logic             tick;
    logic             wire_done;
    logic             slot_done;
    logic [DIV_W-1:0] divisor;
    logic [BIT_W-1:0] wire_len;
    logic [BIT_W-1:0] slot_len;

    assign cfg_in = '{cls: frame_class_e'(frame_class), rate: line_rate_e'(line_rate)};
    assign go     = active_q && enable;

    always_comb begin
        case (cfg_q.rate)
            LR_10M:  divisor = DIV_W'(DIV_10M);
            LR_100M: divisor = DIV_W'(DIV_100M);
            LR_1G:   divisor = DIV_W'(DIV_1G);
            default: divisor = DIV_W'(DIV_10G);
        endcase
        wire_len = BIT_W'(wire_time(cfg_q.cls));
        slot_len = BIT_W'(slot_time(cfg_q.cls));
    end

    // configuration is captured on start and at each slot boundary only
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cfg_q    <= '0;
        end else if (!enable) begin
            active_q <= 1'b0;
        end else if (!active_q || slot_done) begin
            active_q <= 1'b1;
            cfg_q    <= cfg_in;
        end
    end

    bit_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (go),
        .divisor (divisor),
        .tick    (tick)
    );

    frame_slot_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (go),
        .tick      (tick),
        .wire_len  (wire_len),
        .slot_len  (slot_len),
        .wire_done (wire_done),
        .slot_done (slot_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arrival      <= 1'b0;
            frame_blocks <= '0;
            frame_count  <= '0;
        end else begin
            arrival <= go && wire_done;
            if (go && wire_done) begin
                frame_blocks <= BLK_W'(payload_blocks(cfg_q.cls, BLOCK_BYTES));
                frame_count  <= frame_count + CNT_W'(1);
            end
        end
    end

    // R9
    arrival_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        arrival |=> !arrival);

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        arrival |-> (frame_count == CNT_W'($past(frame_count) + 1)));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !arrival |-> $stable(frame_count));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !arrival);

    // R5
    blocks_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !arrival |-> $stable(frame_blocks));

endmodule

// File: tb/eth_worst_arrival_gen_test.sv
module eth_worst_arrival_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;
    localparam int NVEC       = 6;
    // class, rate, first delay, spacing, blocks
    localparam int VEC [NVEC][5] = '{
        '{0, 0, 4608,  5376,  8},
        '{0, 1, 2304,  2688,  8},
        '{0, 2, 1152,  1344,  8},
        '{0, 3, 576,   672,   8},
        '{1, 3, 12208, 12304, 190},
        '{3, 2, 1152,  1344,  8}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  frame_class = 2'b00;
    logic [1:0]  line_rate = 2'b00;
    logic        arrival;
    logic [10:0] frame_blocks;
    logic [15:0] frame_count;

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_worst_arrival_gen uut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .frame_class  (frame_class),
        .line_rate    (line_rate),
        .arrival      (arrival),
        .frame_blocks (frame_blocks),
        .frame_count  (frame_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_arrival(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!arrival && n < limit);
        if (!arrival) n = -1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        int n;
        int highs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 arrival", int'(arrival), 0);
        check("R1 count", int'(frame_count), 0);
        check("R1 blocks", int'(frame_blocks), 0);

        // table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            frame_class = VEC[i][0][1:0];
            line_rate   = VEC[i][1][1:0];
            enable      = 1'b1;
            wait_arrival(20000, n);
            check("R2/R4 first delay", n - 1, VEC[i][2]);
            exp_cnt++;
            check("R5 blocks", int'(frame_blocks), VEC[i][4]);
            check("R6 count", int'(frame_count), exp_cnt);
            wait_arrival(20000, n);
            check("R3 spacing", n, VEC[i][3]);
            exp_cnt++;
            check("R6 count", int'(frame_count), exp_cnt);
            @(negedge clk);
            check("R9 single cycle", int'(arrival), 0);
            enable = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R2 R5 jumbo frame at the fastest rate
        frame_class = 2'b10;
        line_rate   = 2'b11;
        enable      = 1'b1;
        wait_arrival(80000, n);
        check("R2 jumbo delay", n - 1, 72208);
        check("R5 jumbo blocks", int'(frame_blocks), 1128);
        exp_cnt++;
        check("R6 count", int'(frame_count), exp_cnt);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        // R8 change during a frame applies at the next boundary
        frame_class = 2'b00;
        line_rate   = 2'b11;
        enable      = 1'b1;
        repeat (100) @(negedge clk);
        frame_class = 2'b01;
        line_rate   = 2'b10;
        wait_arrival(2000, n);
        check("R8 old timing kept", 100 + n - 1, 576);
        check("R8 old blocks kept", int'(frame_blocks), 8);
        exp_cnt++;
        wait_arrival(30000, n);
        check("R8 new timing", n, 24512);
        check("R8 new blocks", int'(frame_blocks), 190);
        exp_cnt++;
        check("R6 count", int'(frame_count), exp_cnt);
        enable = 1'b0;
        repeat (3) @(negedge clk);

        // R7 abort mid-frame, stay silent, restart from zero
        frame_class = 2'b00;
        line_rate   = 2'b11;
        enable      = 1'b1;
        repeat (300) @(negedge clk);
        enable = 1'b0;
        highs = 0;
        for (int k = 0; k < 700; k++) begin
            @(negedge clk);
            if (arrival) highs++;
        end
        check("R7 no arrival while low", highs, 0);
        check("R7 count held", int'(frame_count), exp_cnt);
        enable = 1'b1;
        wait_arrival(2000, n);
        check("R7 restart delay", n - 1, 576);
        exp_cnt++;
        check("R6 count", int'(frame_count), exp_cnt);

        finish_run();
    end
endmodule